// File: doc/BRIEF.md
# Peripheral Interrupt Status Register

This block collects eight interrupt and event flags for the local microprocessor of an I/O controller board and shows them as one readable status byte. The sources are the host system board (accesses to the board's control register and to its ID/vector register), a SCSI protocol engine, a DMA engine (peripheral fault and two end-of-process events), a SCSI bus-reset detector, and the local firmware itself. The firmware uses the last of these to raise an interrupt request toward the host.

The status byte is active-low: a 0 in a bit means the flag is pending and a 1 means it is idle. Every flag is set by its source. The local processor clears a flag with a strobed access to an address that belongs to that flag alone. Reading the byte has no side effect. Bit 7 drives the host interrupt line. The host clears it when it acknowledges the interrupt.

All inputs are synchronous to one clock. Event inputs are one-cycle pulses and condition inputs are levels. Every effect appears on the outputs one clock after the edge that samples it.

Top module: `pirq_status_reg`

## Requirements
- R1: While `rst_n` is low, the next clock edge drives `status` to 8'hFF and `host_irq_n` high.
- R2: A `fw_host_req` pulse drives `status[7]` to 0 one cycle later. `host_irq_n` always equals `status[7]`.
- R3: `status[7]` returns to 1 on a `host_ack` pulse, or on a strobed local access to address 16'h048F.
- R4: `status[6]` is 0 in every cycle after a cycle in which `spe_irq` was high. Once `spe_irq` is low, the bit returns to 1 on a `spe_irq_rd` pulse or on a strobed access to 16'h0400.
- R5: A `dma_fault` pulse latches `status[5]` to 0. A strobed access to 16'h0480 returns it to 1.
- R6: A `dma_eop_a` pulse latches `status[4]` to 0 and a `dma_eop_b` pulse latches `status[3]` to 0. Strobed accesses to 16'h048C and 16'h0486 return them to 1.
- R7: `status[2]` goes to 0 while `bus_rst_cond` is high. A strobed access to 16'h048A has no effect while the condition persists, and returns the bit to 1 once the condition is gone.
- R8: A `host_ctrl_acc` pulse latches `status[1]` to 0. A strobed access to 16'h0489 returns it to 1.
- R9: A `host_idv_acc` pulse latches `status[0]` to 0 only when `host_intack` is low. With `host_intack` high the pulse has no effect. A strobed access to 16'h0488 returns the bit to 1.
- R10: When a set source and a clear for the same bit arrive in the same cycle, the bit ends up 0 (pending).
- R11: An access at any other address, an address with `loc_strobe` low, or a cycle with no events leaves every bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| loc_strobe | input | 1 | Local bus access strobe, one cycle |
| loc_addr | input | ADDR_W | Local bus address, qualified by `loc_strobe` |
| fw_host_req | input | 1 | Firmware pulse that raises the host interrupt request |
| host_ack | input | 1 | Host acknowledge pulse for the request |
| spe_irq | input | 1 | SCSI protocol engine interrupt level |
| spe_irq_rd | input | 1 | Pulse: engine interrupt register was read |
| dma_fault | input | 1 | Pulse: peripheral fault during a FIFO/memory DMA transfer |
| dma_eop_a | input | 1 | Pulse: first DMA end-of-process event |
| dma_eop_b | input | 1 | Pulse: second DMA end-of-process event |
| bus_rst_cond | input | 1 | SCSI bus reset condition level |
| host_ctrl_acc | input | 1 | Pulse: host accessed the control register |
| host_idv_acc | input | 1 | Pulse: host accessed the ID/vector register |
| host_intack | input | 1 | Level: the current host access is an interrupt-acknowledge cycle |
| status | output | 8 | Active-low status byte |
| host_irq_n | output | 1 | Active-low interrupt request toward the host |

## Verification
The hardest state to reach is a set and a clear for the same bit landing in the same cycle. The same applies to a clear aimed at a bit whose level source is still high. A sequential stimulus never lines these up. Directed steps therefore drive a clear strobe together with the matching event. They also hold `bus_rst_cond` and `spe_irq` high across their clear accesses. A long stretch of sparse random traffic then mixes pulses, level changes and both valid and near-miss addresses. This stretch also catches collisions between different bits in the same cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NFLAG      = 8;
    localparam int CLR_ADDR_W = 16;

    // bit positions inside the status byte (read by firmware)
    localparam int B_IDV   = 0;
    localparam int B_CTRL  = 1;
    localparam int B_BRST  = 2;
    localparam int B_EOPB  = 3;
    localparam int B_EOPA  = 4;
    localparam int B_FAULT = 5;
    localparam int B_SPE   = 6;
    localparam int B_HOST  = 7;

    // dedicated clear address of each flag
    function automatic logic [CLR_ADDR_W-1:0] clr_addr(input int idx);
        logic [CLR_ADDR_W-1:0] a;
        case (idx)
            B_IDV:   a = 16'h0488;
            B_CTRL:  a = 16'h0489;
            B_BRST:  a = 16'h048A;
            B_EOPB:  a = 16'h0486;
            B_EOPA:  a = 16'h048C;
            B_FAULT: a = 16'h0480;
            B_SPE:   a = 16'h0400;
            B_HOST:  a = 16'h048F;
            default: a = '0;
        endcase
        return a;
    endfunction

    // internal state is active-high pending
    typedef struct packed {
        logic [NFLAG-1:0] pend;
    } pirq_state_t;

endpackage

// File: rtl/pirq_clr_decode.sv
module pirq_clr_decode #(
    parameter int ADDR_W = 16,
    parameter int NFLAG  = 8
) (
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    output logic [NFLAG-1:0]  clr_hit
);
    // one comparator per flag against its dedicated clear address
    for (genvar i = 0; i < NFLAG; i++) begin : g_cmp
        assign clr_hit[i] = strobe && (addr == ADDR_W'(pirq_pkg::clr_addr(i)));
    end
endmodule

// File: rtl/pirq_set_map.sv
module pirq_set_map #(
    parameter int NFLAG = 8
) (
    input  logic             fw_host_req,
    input  logic             host_ack,
    input  logic             spe_irq,
    input  logic             spe_irq_rd,
    input  logic             dma_fault,
    input  logic             dma_eop_a,
    input  logic             dma_eop_b,
    input  logic             bus_rst_cond,
    input  logic             host_ctrl_acc,
    input  logic             host_idv_acc,
    input  logic             host_intack,
    output logic [NFLAG-1:0] set_vec,
    output logic [NFLAG-1:0] side_clr
);
    import pirq_pkg::*;

    always_comb begin
        set_vec           = '0;
        set_vec[B_HOST]   = fw_host_req;
        set_vec[B_SPE]    = spe_irq;
        set_vec[B_FAULT]  = dma_fault;
        set_vec[B_EOPA]   = dma_eop_a;
        set_vec[B_EOPB]   = dma_eop_b;
        set_vec[B_BRST]   = bus_rst_cond;
        set_vec[B_CTRL]   = host_ctrl_acc;
        set_vec[B_IDV]    = host_idv_acc && !host_intack;

        // clears that do not come from the local address decoder
        side_clr          = '0;
        side_clr[B_HOST]  = host_ack;
        side_clr[B_SPE]   = spe_irq_rd;
    end
endmodule

// File: rtl/pirq_status_reg.sv
module pirq_status_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_strobe,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              fw_host_req,
    input  logic              host_ack,
    input  logic              spe_irq,
    input  logic              spe_irq_rd,
    input  logic              dma_fault,
    input  logic              dma_eop_a,
    input  logic              dma_eop_b,
    input  logic              bus_rst_cond,
    input  logic              host_ctrl_acc,
    input  logic              host_idv_acc,
    input  logic              host_intack,
    output logic [7:0]        status,
    output logic              host_irq_n
);
    import pirq_pkg::*;

    logic [NFLAG-1:0] clr_hit;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] side_clr;
    pirq_state_t      st_d;
    pirq_state_t      st_q;

    pirq_clr_decode #(.ADDR_W(ADDR_W), .NFLAG(NFLAG)) u_dec (
        .strobe  (loc_strobe),
        .addr    (loc_addr),
        .clr_hit (clr_hit)
    );

    pirq_set_map #(.NFLAG(NFLAG)) u_map (
        .fw_host_req   (fw_host_req),
        .host_ack      (host_ack),
        .spe_irq       (spe_irq),
        .spe_irq_rd    (spe_irq_rd),
        .dma_fault     (dma_fault),
        .dma_eop_a     (dma_eop_a),
        .dma_eop_b     (dma_eop_b),
        .bus_rst_cond  (bus_rst_cond),
        .host_ctrl_acc (host_ctrl_acc),
        .host_idv_acc  (host_idv_acc),
        .host_intack   (host_intack),
        .set_vec       (set_vec),
        .side_clr      (side_clr)
    );

    // set has priority over clear so that no event is dropped
    always_comb begin
        st_d      = st_q;
        st_d.pend = set_vec | (st_q.pend & ~(clr_hit | side_clr));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status     = ~st_q.pend;
    assign host_irq_n = ~st_q.pend[B_HOST];

endmodule

// File: rtl/pirq_status_chk.sv
module pirq_status_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_strobe,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              fw_host_req,
    input logic              host_ack,
    input logic              spe_irq,
    input logic              spe_irq_rd,
    input logic              dma_fault,
    input logic              dma_eop_a,
    input logic              dma_eop_b,
    input logic              bus_rst_cond,
    input logic              host_ctrl_acc,
    input logic              host_idv_acc,
    input logic              host_intack,
    input logic [7:0]        status,
    input logic              host_irq_n
);
    logic quiet;
    assign quiet = !loc_strobe && !fw_host_req && !host_ack && !spe_irq && !spe_irq_rd
                && !dma_fault && !dma_eop_a && !dma_eop_b && !bus_rst_cond
                && !host_ctrl_acc && !host_idv_acc;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (status == 8'hFF && host_irq_n)); // R1

    AST_HOST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        fw_host_req |=> !host_irq_n); // R2

    AST_HOST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !fw_host_req) |=> host_irq_n); // R3

    AST_FAULT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_strobe && loc_addr == ADDR_W'(16'h0480) && !dma_fault) |=> status[5]); // R5

    AST_BRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_cond |=> !status[2]); // R7

    AST_INTACK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_intack && !loc_strobe) |=> (status[0] == $past(status[0]))); // R9

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_eop_a && loc_strobe && loc_addr == ADDR_W'(16'h048C)) |=> !status[4]); // R10

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(status)); // R11

endmodule

bind pirq_status_reg pirq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .loc_strobe    (loc_strobe),
    .loc_addr      (loc_addr),
    .fw_host_req   (fw_host_req),
    .host_ack      (host_ack),
    .spe_irq       (spe_irq),
    .spe_irq_rd    (spe_irq_rd),
    .dma_fault     (dma_fault),
    .dma_eop_a     (dma_eop_a),
    .dma_eop_b     (dma_eop_b),
    .bus_rst_cond  (bus_rst_cond),
    .host_ctrl_acc (host_ctrl_acc),
    .host_idv_acc  (host_idv_acc),
    .host_intack   (host_intack),
    .status        (status),
    .host_irq_n    (host_irq_n)
);

// File: tb/pirq_status_reg_bench.sv
`timescale 1ns/1ps
module pirq_status_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        loc_strobe;
    logic [15:0] loc_addr;
    logic        fw_host_req, host_ack, spe_irq, spe_irq_rd;
    logic        dma_fault, dma_eop_a, dma_eop_b, bus_rst_cond;
    logic        host_ctrl_acc, host_idv_acc, host_intack;
    logic [7:0]  status;
    logic        host_irq_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    logic [7:0] m_pend = 8'h00;   // model: 1 = pending
    logic [7:0] m_nx;

    always #2.5 clk = ~clk;

    pirq_status_reg #(.ADDR_W(16)) u_pirq_status_reg (
        .clk(clk), .rst_n(rst_n), .loc_strobe(loc_strobe), .loc_addr(loc_addr),
        .fw_host_req(fw_host_req), .host_ack(host_ack), .spe_irq(spe_irq),
        .spe_irq_rd(spe_irq_rd), .dma_fault(dma_fault), .dma_eop_a(dma_eop_a),
        .dma_eop_b(dma_eop_b), .bus_rst_cond(bus_rst_cond),
        .host_ctrl_acc(host_ctrl_acc), .host_idv_acc(host_idv_acc),
        .host_intack(host_intack), .status(status), .host_irq_n(host_irq_n)
    );

    // behavioural reference: clears first, then every set source on top
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend <= 8'h00;
        end else begin
            m_nx = m_pend;
            if (loc_strobe) begin
                case (loc_addr)
                    16'h048F: m_nx[7] = 1'b0;
                    16'h0400: m_nx[6] = 1'b0;
                    16'h0480: m_nx[5] = 1'b0;
                    16'h048C: m_nx[4] = 1'b0;
                    16'h0486: m_nx[3] = 1'b0;
                    16'h048A: m_nx[2] = 1'b0;
                    16'h0489: m_nx[1] = 1'b0;
                    16'h0488: m_nx[0] = 1'b0;
                    default:  ;
                endcase
            end
            if (host_ack)    m_nx[7] = 1'b0;
            if (spe_irq_rd)  m_nx[6] = 1'b0;
            if (fw_host_req) m_nx[7] = 1'b1;
            if (spe_irq)     m_nx[6] = 1'b1;
            if (dma_fault)   m_nx[5] = 1'b1;
            if (dma_eop_a)   m_nx[4] = 1'b1;
            if (dma_eop_b)   m_nx[3] = 1'b1;
            if (bus_rst_cond) m_nx[2] = 1'b1;
            if (host_ctrl_acc) m_nx[1] = 1'b1;
            if (host_idv_acc && !host_intack) m_nx[0] = 1'b1;
            m_pend <= m_nx;
        end
    end

    function automatic string req_of(input int b);
        case (b)
            7: return "R2 R3";
            6: return "R4";
            5: return "R5";
            4, 3: return "R6";
            2: return "R7";
            1: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare();
        for (int b = 0; b < 8; b++) begin
            n_cmp++;
            if (status[b] !== ~m_pend[b]) begin
                n_bad++;
                $display("FAIL [%s] %s status[%0d] actual=%b expected=%b",
                         phase, req_of(b), b, status[b], ~m_pend[b]);
            end
        end
        n_cmp++;
        if (host_irq_n !== ~m_pend[7]) begin
            n_bad++;
            $display("FAIL [%s] R2 host_irq_n actual=%b expected=%b",
                     phase, host_irq_n, ~m_pend[7]);
        end
    endtask

    // one clock, compare away from the edge, then drop pulse inputs
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        loc_strobe = 1'b0; fw_host_req = 1'b0; host_ack = 1'b0; spe_irq_rd = 1'b0;
        dma_fault = 1'b0; dma_eop_a = 1'b0; dma_eop_b = 1'b0;
        host_ctrl_acc = 1'b0; host_idv_acc = 1'b0;
    endtask

    task automatic clr_at(input logic [15:0] a);
        loc_strobe = 1'b1;
        loc_addr   = a;
        tick();
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] pool [10];
        pool = '{16'h048F, 16'h0400, 16'h0480, 16'h048C, 16'h0486,
                 16'h048A, 16'h0489, 16'h0488, 16'h0481, 16'h0487};

        rst_n = 1'b0; loc_strobe = 1'b0; loc_addr = '0;
        fw_host_req = 1'b0; host_ack = 1'b0; spe_irq = 1'b0; spe_irq_rd = 1'b0;
        dma_fault = 1'b0; dma_eop_a = 1'b0; dma_eop_b = 1'b0; bus_rst_cond = 1'b0;
        host_ctrl_acc = 1'b0; host_idv_acc = 1'b0; host_intack = 1'b0;

        phase = "R1 reset";
        // sources active during reset must not leak through
        bus_rst_cond = 1'b1; fw_host_req = 1'b1;
        tick(); tick(); bus_rst_cond = 1'b0; tick();
        rst_n = 1'b1; tick();

        phase = "R2 raise";
        fw_host_req = 1'b1; tick(); tick();
        phase = "R3 ack";
        host_ack = 1'b1; tick();
        fw_host_req = 1'b1; tick();
        clr_at(16'h048F); tick();

        phase = "R4 engine level";
        spe_irq = 1'b1; tick();
        spe_irq_rd = 1'b1; tick();
        clr_at(16'h0400);
        spe_irq = 1'b0; tick();
        clr_at(16'h0400);
        spe_irq = 1'b1; tick();
        spe_irq = 1'b0; spe_irq_rd = 1'b1; tick();

        phase = "R5 fault";
        dma_fault = 1'b1; tick(); tick();
        clr_at(16'h0480);

        phase = "R6 eop";
        dma_eop_a = 1'b1; dma_eop_b = 1'b1; tick();
        clr_at(16'h048C);
        clr_at(16'h0486);

        phase = "R7 bus reset";
        bus_rst_cond = 1'b1; tick();
        clr_at(16'h048A); clr_at(16'h048A);
        bus_rst_cond = 1'b0; tick();
        clr_at(16'h048A);

        phase = "R8 control access";
        host_ctrl_acc = 1'b1; tick();
        clr_at(16'h0489);

        phase = "R9 id/vector access";
        host_intack = 1'b1; host_idv_acc = 1'b1; tick();
        host_intack = 1'b0; host_idv_acc = 1'b1; tick();
        clr_at(16'h0488);

        phase = "R10 collision";
        dma_fault = 1'b1; clr_at(16'h0480);
        fw_host_req = 1'b1; host_ack = 1'b1; tick();
        host_ctrl_acc = 1'b1; clr_at(16'h0489);
        dma_eop_a = 1'b1; clr_at(16'h048C);

        phase = "R11 no effect";
        dma_eop_b = 1'b1; host_idv_acc = 1'b1; tick();
        clr_at(16'h0481); clr_at(16'h0000); clr_at(16'h048E); clr_at(16'h0C86);
        loc_addr = 16'h0486; tick();
        loc_addr = 16'h0488; tick(); tick();

        phase = "R10 R11 random";
        for (int c = 0; c < 3000; c++) begin
            loc_strobe    = ($urandom % 4) == 0;
            loc_addr      = (($urandom % 8) == 0) ? 16'($urandom) : pool[$urandom % 10];
            fw_host_req   = ($urandom % 12) == 0;
            host_ack      = ($urandom % 10) == 0;
            spe_irq_rd    = ($urandom % 10) == 0;
            dma_fault     = ($urandom % 12) == 0;
            dma_eop_a     = ($urandom % 12) == 0;
            dma_eop_b     = ($urandom % 12) == 0;
            host_ctrl_acc = ($urandom % 12) == 0;
            host_idv_acc  = ($urandom % 8) == 0;
            if (($urandom % 16) == 0) spe_irq      = ~spe_irq;
            if (($urandom % 20) == 0) bus_rst_cond = ~bus_rst_cond;
            if (($urandom % 6) == 0)  host_intack  = ~host_intack;
            tick();
        end

        phase = "R1 reset again";
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        spe_irq = 1'b0; bus_rst_cond = 1'b0; host_intack = 1'b0;
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule